// File: doc/BRIEF.md
# System Bus Trace Entry Formatter

This block watches an on-chip system bus and turns selected bus cycles into 128-bit records for a trace memory. Two trigger strobes, one for the address phase and one for the data phase, choose the cycles to record. Each recorded cycle yields one control entry. The control entry holds the following fields:

- which of the four doublewords carry valid bytes;
- the cacheability attribute;
- the command code;
- the cache line address;
- the transaction ID;
- a saturating count of idle cycles since the last entry;
- two flags that give the cause of the capture.

When the data-phase trigger causes the capture, two more entries follow. They carry the 256-bit data beat, upper half first.

The upstream trigger sequencer drives the strobes. The formatter writes the trace memory through a single write enable and a 128-bit write word. A separate trace-clear input restarts the cycle count and does not touch the write path. Records vary in length: one entry for an address capture, three entries for a data capture.

Top module: `trace_capture_fmt`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `buf_we` is low. The cycle counter starts from zero.
- R2: A trigger that is sampled while no data entries are pending produces a control entry on `buf_wdata`, with `buf_we` high, in the cycle after the sampling edge. The entry is laid out as follows: bits 68:66 hold `bus_cmd` unchanged, including the reserved values 101 and 110 and the no-command value 111; bits 65:64 hold `bus_attr` unchanged; bits 103:69 hold `bus_line`; bits 113:104 hold `bus_id`, with the requester number in 113:110 and its tag in 109:104; bits 59:0 are zero.
- R3: Bit 60+n of the control entry, for n = 0..3, is the OR of `bus_be[8n+7:8n]`.
- R4: Bits 125:114 of the control entry hold the number of clock edges since the previous entry was written, with no entry written at those edges. Back-to-back entries give 0. The count saturates at 4095 and stays there until an entry is written.
- R5: `trace_clr` sampled high forces the count to zero. A capture at that same edge reports 0, and the count then restarts from that edge.
- R6: Bit 127 of a control entry is set exactly when `trig_addr` caused the capture.
- R7: Bit 126 of a control entry is set exactly when `trig_data` caused the capture. In the two following cycles `buf_we` stays high and `buf_wdata` carries `bus_data[255:128]` and then `bus_data[127:0]`, both sampled at the trigger edge.
- R8: Triggers sampled at the two edges that emit data entries are dropped. No extra entry appears, and the next capture after that counts from the last data entry.
- R9: When both triggers are sampled together, a single control entry is written with bits 127 and 126 both set, followed by the two data entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trace_clr | input | 1 | Restart the inter-entry cycle count |
| trig_addr | input | 1 | Address-phase capture strobe |
| trig_data | input | 1 | Data-phase capture strobe |
| bus_be | input | 32 | Byte enables of the 32-byte beat |
| bus_attr | input | 2 | Cacheability attribute |
| bus_cmd | input | 3 | Address-phase command |
| bus_line | input | 35 | Line address, bus address bits 39:5 |
| bus_id | input | 10 | Transaction ID (requester and tag) |
| bus_data | input | 256 | Data beat |
| buf_we | output | 1 | Trace memory write enable |
| buf_wdata | output | 128 | Trace memory write word |

## Verification
A control entry appears exactly one cycle after the edge that samples its trigger. The two data entries follow at the second and third cycles, and their data was latched at the trigger edge. The bench model applies each sampled input at the same edge as the design. It then compares the write port 2 ns after that edge, so every expected value lines up with the register that produces it. The count field is predicted by counting edges in the model, which makes the saturation wait and a clear that coincides with a capture land on the exact cycle.

// File: rtl/trace_fmt_pkg.sv
package trace_fmt_pkg;

    localparam int BE_W    = 32;
    localparam int DW_N    = BE_W / 8;
    localparam int ENTRY_W = 128;
    localparam int DATA_W  = 2 * ENTRY_W;
    localparam int CNT_W   = 12;
    localparam int LINE_W  = 35;
    localparam int ID_W    = 10;
    localparam int CMD_W   = 3;
    localparam int ATTR_W  = 2;
    localparam int PAD_W   = ENTRY_W - 2 - CNT_W - ID_W - LINE_W - CMD_W - ATTR_W - DW_N;

    typedef enum logic [CMD_W-1:0] {
        CMD_RD_SHARED = 3'b000,
        CMD_RD_EXCL   = 3'b001,
        CMD_WRITE     = 3'b010,
        CMD_WR_INVAL  = 3'b011,
        CMD_INVAL     = 3'b100,
        CMD_NONE      = 3'b111
    } bus_cmd_e;

    typedef enum logic [ATTR_W-1:0] {
        ATTR_NONCOH   = 2'b00,
        ATTR_COHERENT = 2'b01,
        ATTR_UNCACHED = 2'b10,
        ATTR_UNC_ACC  = 2'b11
    } bus_attr_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HI   = 2'd1,
        PH_LO   = 2'd2
    } phase_e;

    typedef struct packed {
        logic              by_addr;
        logic              by_data;
        logic [CNT_W-1:0]  gap;
        logic [ID_W-1:0]   id;
        logic [LINE_W-1:0] line;
        logic [CMD_W-1:0]  cmd;
        logic [ATTR_W-1:0] attr;
        logic [DW_N-1:0]   dw_valid;
        logic [PAD_W-1:0]  pad;
    } ctrl_entry_t;

    function automatic logic [CNT_W-1:0] gap_next(input logic [CNT_W-1:0] cur);
        return (&cur) ? cur : cur + 1'b1;
    endfunction

endpackage

// File: rtl/trace_gap_ctr.sv
module trace_gap_ctr #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         wr,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr || wr) cnt <= '0;
        else if (~&cnt)       cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/trace_ctrl_pack.sv
module trace_ctrl_pack
    import trace_fmt_pkg::*;
(
    input  logic              by_addr,
    input  logic              by_data,
    input  logic [BE_W-1:0]   be,
    input  logic [ATTR_W-1:0] attr,
    input  logic [CMD_W-1:0]  cmd,
    input  logic [LINE_W-1:0] line,
    input  logic [ID_W-1:0]   id,
    input  logic [CNT_W-1:0]  gap,
    output ctrl_entry_t       entry
);
    logic [DW_N-1:0] dw;

    for (genvar g = 0; g < DW_N; g++) begin : g_dw
        assign dw[g] = |be[8*g +: 8];
    end

    always_comb begin
        entry          = '0;
        entry.by_addr  = by_addr;
        entry.by_data  = by_data;
        entry.gap      = gap;
        entry.id       = id;
        entry.line     = line;
        entry.cmd      = cmd;
        entry.attr     = attr;
        entry.dw_valid = dw;
    end
endmodule

// File: rtl/trace_beat_seq.sv
module trace_beat_seq
    import trace_fmt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               by_addr,
    input  logic               by_data,
    input  logic [ENTRY_W-1:0] ctrl_word,
    input  logic [DATA_W-1:0]  data,
    output logic               take,
    output phase_e             phase,
    output logic               we,
    output logic [ENTRY_W-1:0] wdata
);
    logic [DATA_W-1:0] hold;

    assign take = (phase != PH_IDLE) || by_addr || by_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            we    <= 1'b0;
            wdata <= '0;
            hold  <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    we <= by_addr || by_data;
                    if (by_addr || by_data) wdata <= ctrl_word;
                    if (by_data) begin
                        hold  <= data;
                        phase <= PH_HI;
                    end
                end
                PH_HI: begin
                    we    <= 1'b1;
                    wdata <= hold[DATA_W-1 -: ENTRY_W];
                    phase <= PH_LO;
                end
                PH_LO: begin
                    we    <= 1'b1;
                    wdata <= hold[ENTRY_W-1:0];
                    phase <= PH_IDLE;
                end
                default: begin
                    we    <= 1'b0;
                    phase <= PH_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/trace_capture_fmt.sv
module trace_capture_fmt
    import trace_fmt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               trace_clr,
    input  logic               trig_addr,
    input  logic               trig_data,
    input  logic [BE_W-1:0]    bus_be,
    input  logic [ATTR_W-1:0]  bus_attr,
    input  logic [CMD_W-1:0]   bus_cmd,
    input  logic [LINE_W-1:0]  bus_line,
    input  logic [ID_W-1:0]    bus_id,
    input  logic [DATA_W-1:0]  bus_data,
    output logic               buf_we,
    output logic [ENTRY_W-1:0] buf_wdata
);
    logic [CNT_W-1:0] gap_w;
    logic [CNT_W-1:0] gap_eff;
    logic             take_w;
    phase_e           phase_w;
    ctrl_entry_t      entry_w;

    assign gap_eff = trace_clr ? '0 : gap_w;

    trace_gap_ctr #(.W(CNT_W)) u_gap (
        .clk (clk),
        .rst (rst),
        .clr (trace_clr),
        .wr  (take_w),
        .cnt (gap_w)
    );

    trace_ctrl_pack u_pack (
        .by_addr (trig_addr),
        .by_data (trig_data),
        .be      (bus_be),
        .attr    (bus_attr),
        .cmd     (bus_cmd),
        .line    (bus_line),
        .id      (bus_id),
        .gap     (gap_eff),
        .entry   (entry_w)
    );

    trace_beat_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .by_addr   (trig_addr),
        .by_data   (trig_data),
        .ctrl_word (entry_w),
        .data      (bus_data),
        .take      (take_w),
        .phase     (phase_w),
        .we        (buf_we),
        .wdata     (buf_wdata)
    );
endmodule

// File: rtl/trace_capture_fmt_chk.sv
module trace_capture_fmt_chk
    import trace_fmt_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               clr,
    input logic               ta,
    input logic               td,
    input logic               we,
    input logic [ENTRY_W-1:0] wd,
    input phase_e             phase,
    input logic [CNT_W-1:0]   gap
);
    localparam logic [CNT_W-1:0] GMAX = '1;

    a_r1_quiet_after_reset: assert property (@(posedge clk) rst |=> !we);

    a_r2_capture_next: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && (ta || td)) |=> we);

    a_r4_sat_hold: assert property (@(posedge clk) disable iff (rst)
        (gap == GMAX && phase == PH_IDLE && !ta && !td && !clr) |=> gap == GMAX);

    a_r5_clr_zero: assert property (@(posedge clk) disable iff (rst)
        clr |=> gap == '0);

    a_r6_addr_flag: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && ta) |=> wd[ENTRY_W-1]);

    a_r7_hi_beat: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && td) |=> (wd[ENTRY_W-2] && phase == PH_HI));

    a_r8_busy_writes: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) |=> we);
endmodule

bind trace_capture_fmt trace_capture_fmt_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .clr   (trace_clr),
    .ta    (trig_addr),
    .td    (trig_data),
    .we    (buf_we),
    .wd    (buf_wdata),
    .phase (phase_w),
    .gap   (gap_w)
);

// File: tb/trace_capture_fmt_tb.sv
module trace_capture_fmt_tb;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         trace_clr = 1'b0;
    logic         trig_addr = 1'b0;
    logic         trig_data = 1'b0;
    logic [31:0]  bus_be = '0;
    logic [1:0]   bus_attr = '0;
    logic [2:0]   bus_cmd = 3'b111;
    logic [34:0]  bus_line = '0;
    logic [9:0]   bus_id = '0;
    logic [255:0] bus_data = '0;
    logic         buf_we;
    logic [127:0] buf_wdata;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    string en_req = "R1";
    string gap_req = "R4";

    always #5 clk = ~clk;

    trace_capture_fmt u_dut (
        .clk(clk), .rst(rst), .trace_clr(trace_clr),
        .trig_addr(trig_addr), .trig_data(trig_data),
        .bus_be(bus_be), .bus_attr(bus_attr), .bus_cmd(bus_cmd),
        .bus_line(bus_line), .bus_id(bus_id), .bus_data(bus_data),
        .buf_we(buf_we), .buf_wdata(buf_wdata)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
        end
    endtask

    // Reference model: state kept in plain integers and vectors
    int           m_gap = 0;
    int           m_pend = 0;
    logic [255:0] m_hold = '0;
    bit           e_we;
    int           e_kind;  // 0 control, 1 upper data, 2 lower data
    logic [127:0] e_word;

    always @(posedge clk) begin
        bit wrote;
        cyc++;
        wrote = 0;
        e_we = 0;
        if (rst) begin
            m_gap = 0; m_pend = 0;
        end else begin
            if (m_pend == 2) begin
                e_we = 1; e_kind = 1; e_word = m_hold[255:128]; m_pend = 1; wrote = 1;
            end else if (m_pend == 1) begin
                e_we = 1; e_kind = 2; e_word = m_hold[127:0]; m_pend = 0; wrote = 1;
            end else if (trig_addr || trig_data) begin
                e_we = 1; e_kind = 0; wrote = 1;
                e_word = '0;
                e_word[127] = trig_addr;
                e_word[126] = trig_data;
                e_word[125:114] = trace_clr ? 12'd0 : 12'(m_gap);
                e_word[113:104] = bus_id;
                e_word[103:69] = bus_line;
                e_word[68:66] = bus_cmd;
                e_word[65:64] = bus_attr;
                for (int n = 0; n < 4; n++) e_word[60+n] = (bus_be[8*n +: 8] != 8'h00);
                if (trig_data) begin m_hold = bus_data; m_pend = 2; end
            end
            if (trace_clr || wrote) m_gap = 0;
            else if (m_gap < 4095) m_gap = m_gap + 1;
        end
        #2;
        chk(buf_we === e_we, en_req, 128'(buf_we), 128'(e_we));
        if (e_we && buf_we === 1'b1) begin
            if (e_kind == 0) begin
                chk(buf_wdata[63:60] === e_word[63:60], "R3", 128'(buf_wdata[63:60]), 128'(e_word[63:60]));
                chk(buf_wdata[125:114] === e_word[125:114], gap_req, 128'(buf_wdata[125:114]), 128'(e_word[125:114]));
                chk(buf_wdata[127] === e_word[127], "R6", 128'(buf_wdata[127]), 128'(e_word[127]));
                chk(buf_wdata[126] === e_word[126], "R7/R9", 128'(buf_wdata[126]), 128'(e_word[126]));
                chk({buf_wdata[113:64], buf_wdata[59:0]} === {e_word[113:64], e_word[59:0]}, "R2",
                    buf_wdata, e_word);
            end else begin
                chk(buf_wdata === e_word, "R7", buf_wdata, e_word);
            end
        end
    end

    task automatic drive(input bit a, input bit d, input bit c, input logic [31:0] be, input logic [2:0] cmd);
        trig_addr = a; trig_data = d; trace_clr = c; bus_be = be; bus_cmd = cmd;
        bus_attr = 2'($urandom);
        bus_line = {3'($urandom), $urandom};
        bus_id = 10'($urandom);
        bus_data = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 32'h0, 3'b111);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        idle(2);
        en_req = "R2";
        // R2, R3, R6: address captures with various enable patterns and commands
        drive(1, 0, 0, 32'h0000_00F0, 3'b001);
        idle(4);
        drive(1, 0, 0, 32'hFFFF_FFFF, 3'b010);
        drive(1, 0, 0, 32'h0100_0000, 3'b101);  // R4 back-to-back, reserved command
        drive(1, 0, 0, 32'h0000_8000, 3'b110);
        drive(1, 0, 0, 32'h0000_0000, 3'b111);
        idle(3);
        // R7: data capture, R8: triggers during data beats dropped
        en_req = "R7";
        drive(0, 1, 0, 32'h00FF_0000, 3'b000);
        en_req = "R8";
        drive(1, 0, 0, 32'h1, 3'b011);
        drive(1, 1, 0, 32'h1, 3'b100);
        drive(1, 0, 0, 32'h2, 3'b000);          // counts from last data entry: 0
        idle(2);
        // R9: both triggers together
        en_req = "R9";
        drive(1, 1, 0, 32'h8001_0080, 3'b011);
        idle(4);
        // R5: clear alone, then clear coinciding with a capture
        en_req = "R5"; gap_req = "R5";
        idle(5);
        drive(0, 0, 1, 32'h0, 3'b111);
        idle(2);
        drive(1, 0, 0, 32'h0000_0F00, 3'b000);
        idle(6);
        drive(1, 0, 1, 32'h0F00_0000, 3'b100);
        idle(2);
        // R4: saturation at 4095
        en_req = "R4"; gap_req = "R4";
        idle(4200);
        drive(0, 1, 0, 32'hF0F0_F0F0, 3'b010);
        idle(3);
        drive(1, 0, 0, 32'h1, 3'b000);
        idle(3);
        // R1: reset mid-record
        en_req = "R1";
        drive(0, 1, 0, 32'h1, 3'b000);
        rst = 1;
        idle(3);
        rst = 0;
        en_req = "R2";
        idle(2);
        drive(1, 0, 0, 32'h3000_0000, 3'b001);  // count after reset starts from zero
        idle(3);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule